// File: doc/BRIEF.md
# Reshapeable Two-Dimensional Multi-Bank Register File

This block stores a two-dimensional array of 64-bit elements and spreads it over P×Q independent memory banks, so that any P×Q rectangle of neighbouring elements can be read or written in one cycle. Software sees logical registers. Each register is a rectangle inside the array, described by a table entry that holds its top-left corner, its height, its width and an element-width code. An access names a register and an offset inside it. The block then touches the P×Q block whose top-left corner is the register corner plus the offset.

There are two read ports and one write port. Each port has its own address generator. The generator expands the access into the coordinates of every lane. It maps each coordinate to a bank and to an address inside that bank, and it computes the inverse map from bank to lane. Full crossbars use these maps to steer data between lanes and banks. The descriptor table can be rewritten at any time. This resizes or moves a register while the access fields stay the same.

Top module: `prf_rf`

## Requirements
- R1: While reset is held and after its release, rd0_err, rd1_err and wr_err are low. Read data stays zero until the first clock edge after release. Every descriptor covers the whole array: corner (0,0), height H, width W, width code 3.
- R2: Element (i,j) is row i, column j. An access with register g and offset (orow,ocol) covers the P×Q block whose top-left corner is (base_row+orow, base_col+ocol). Lane l = dr*Q+dc carries element (top+dr, left+dc) in data bits [l*64 +: 64].
- R3: A block at any row and column alignment is transferred in a single cycle. Read data and flags appear on the clock edge after the request. A write is seen by reads requested in the following cycle.
- R4: Element (i,j) lives in bank (i mod P)*Q + (j mod Q), so the lanes of every access map one-to-one onto the banks.
- R5: The two read ports serve different registers and offsets in the same cycle, independently.
- R6: A read and a write to the same element in the same cycle return the value held before the write.
- R7: A descriptor write (cfg_we) replaces entry cfg_idx. Accesses issued from the next cycle on use the new corner and size, with unchanged access fields. Each read returns the register's width code on rdN_ew, alongside the data.
- R8: An access is in error when orow+P exceeds the register height or ocol+Q exceeds its width. A read in error raises rdN_err and returns zero data.
- R9: An access is in error when the block passes the array edge, that is top+P > H or left+Q > W. This applies even when the register extent allows the access. The response is the same as in R8.
- R10: A write in error changes no element, and wr_err is high for the one cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Descriptor entry to write |
| cfg_row | input | 3 | New top row |
| cfg_col | input | 3 | New left column |
| cfg_vlen | input | 4 | New height in rows |
| cfg_hlen | input | 4 | New width in columns |
| cfg_ew | input | 2 | New element-width code (0:8, 1:16, 2:32, 3:64 bit) |
| wr_en | input | 1 | Write request |
| wr_reg | input | 3 | Register written |
| wr_orow | input | 3 | Row offset inside the register |
| wr_ocol | input | 3 | Column offset inside the register |
| wr_data | input | 256 | Write lanes, lane l in bits [l*64 +: 64] |
| wr_err | output | 1 | Previous write was out of bounds and was dropped |
| rd0_reg | input | 3 | Read port 0 register |
| rd0_orow | input | 3 | Read port 0 row offset |
| rd0_ocol | input | 3 | Read port 0 column offset |
| rd0_data | output | 256 | Read port 0 lanes |
| rd0_err | output | 1 | Read port 0 access out of bounds |
| rd0_ew | output | 2 | Read port 0 element-width code |
| rd1_reg | input | 3 | Read port 1 register |
| rd1_orow | input | 3 | Read port 1 row offset |
| rd1_ocol | input | 3 | Read port 1 column offset |
| rd1_data | output | 256 | Read port 1 lanes |
| rd1_err | output | 1 | Read port 1 access out of bounds |
| rd1_ew | output | 2 | Read port 1 element-width code |

## Verification
The array is first filled with aligned block writes. It is then read back at every one of the 49 block positions on both ports at once, with the two ports sweeping in opposite directions. Because every bank-row and bank-column phase occurs, a wrong bank map, intra-bank address or inverse lane map gives a wrong lane. A second pass writes at every unaligned position, so the blocks overlap. It checks the final contents, which tells write-crossbar faults apart from read-crossbar faults. Small registers placed near an edge separate register-extent errors from array-edge errors. A descriptor rewrite, a dropped write and a read-during-write to the same element cover the remaining orderings.

// File: rtl/prf_pkg.sv
package prf_pkg;

   typedef enum logic [1:0] {
      EW_8  = 2'd0,
      EW_16 = 2'd1,
      EW_32 = 2'd2,
      EW_64 = 2'd3
   } elem_w_e;

   localparam int NUM_RD = 2;          // read ports
   localparam int NUM_AG = NUM_RD + 1; // address generators: write port first

endpackage

// File: rtl/prf_desc_table.sv
module prf_desc_table #(
   parameter int NREG  = 8,
   parameter int NPORT = 3,
   parameter int H     = 8,
   parameter int W     = 8,
   parameter int RIW   = 3,
   parameter int RW    = 3,
   parameter int CW    = 3,
   parameter int LRW   = 4,
   parameter int LCW   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [RIW-1:0] cfg_idx,
   input  logic [RW-1:0]  cfg_row,
   input  logic [CW-1:0]  cfg_col,
   input  logic [LRW-1:0] cfg_vlen,
   input  logic [LCW-1:0] cfg_hlen,
   input  logic [1:0]     cfg_ew,
   input  logic [RIW-1:0] look_idx  [NPORT],
   output logic [RW-1:0]  look_row  [NPORT],
   output logic [CW-1:0]  look_col  [NPORT],
   output logic [LRW-1:0] look_vlen [NPORT],
   output logic [LCW-1:0] look_hlen [NPORT],
   output logic [1:0]     look_ew   [NPORT]
);
   import prf_pkg::*;

   logic [RW-1:0]  t_row  [NREG];
   logic [CW-1:0]  t_col  [NREG];
   logic [LRW-1:0] t_vlen [NREG];
   logic [LCW-1:0] t_hlen [NREG];
   logic [1:0]     t_ew   [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            t_row[k]  <= '0;
            t_col[k]  <= '0;
            t_vlen[k] <= LRW'(H);
            t_hlen[k] <= LCW'(W);
            t_ew[k]   <= EW_64;
         end else if (cfg_we && (cfg_idx == RIW'(k))) begin
            t_row[k]  <= cfg_row;
            t_col[k]  <= cfg_col;
            t_vlen[k] <= cfg_vlen;
            t_hlen[k] <= cfg_hlen;
            t_ew[k]   <= cfg_ew;
         end
      end
   end

   for (genvar n = 0; n < NPORT; n++) begin : g_look
      assign look_row[n]  = t_row[look_idx[n]];
      assign look_col[n]  = t_col[look_idx[n]];
      assign look_vlen[n] = t_vlen[look_idx[n]];
      assign look_hlen[n] = t_hlen[look_idx[n]];
      assign look_ew[n]   = t_ew[look_idx[n]];
   end

endmodule

// File: rtl/prf_agu.sv
module prf_agu #(
   parameter int P   = 2,
   parameter int Q   = 2,
   parameter int H   = 8,
   parameter int W   = 8,
   parameter int RW  = 3,
   parameter int CW  = 3,
   parameter int LRW = 4,
   parameter int LCW = 4,
   parameter int AW  = 4,
   parameter int BIW = 2,
   localparam int LANES = P * Q
) (
   input  logic [RW-1:0]  base_r,
   input  logic [CW-1:0]  base_c,
   input  logic [LRW-1:0] vlen,
   input  logic [LCW-1:0] hlen,
   input  logic [RW-1:0]  off_r,
   input  logic [CW-1:0]  off_c,
   output logic [BIW-1:0] lane_bank [LANES],
   output logic [BIW-1:0] bank_lane [LANES],
   output logic [AW-1:0]  bank_addr [LANES],
   output logic           err
);
   localparam int EXT = RW + CW + 3;
   localparam logic [EXT-1:0] PE  = EXT'(P);
   localparam logic [EXT-1:0] QE  = EXT'(Q);
   localparam logic [EXT-1:0] HE  = EXT'(H);
   localparam logic [EXT-1:0] WE  = EXT'(W);
   localparam logic [EXT-1:0] WQE = EXT'(W / Q);

   logic [EXT-1:0] abs_r, abs_c, ph_r, ph_c;
   logic [AW-1:0]  lane_addr [LANES];

   assign abs_r = EXT'(base_r) + EXT'(off_r);
   assign abs_c = EXT'(base_c) + EXT'(off_c);
   assign ph_r  = abs_r % PE;
   assign ph_c  = abs_c % QE;

   // extent of the register, then edge of the array
   assign err = (EXT'(off_r) + PE > EXT'(vlen)) ||
                (EXT'(off_c) + QE > EXT'(hlen)) ||
                (abs_r + PE > HE) ||
                (abs_c + QE > WE);

   // forward map: lane -> bank, intra-bank address
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [EXT-1:0] DR = EXT'(l / Q);
      localparam logic [EXT-1:0] DC = EXT'(l % Q);
      logic [EXT-1:0] r, c, bk, ad;
      assign r  = abs_r + DR;
      assign c  = abs_c + DC;
      assign bk = (r % PE) * QE + (c % QE);
      assign ad = (r / PE) * WQE + (c / QE);
      assign lane_bank[l] = bk[BIW-1:0];
      assign lane_addr[l] = ad[AW-1:0];
   end

   // inverse map: bank -> lane, used to route addresses and write data
   for (genvar b = 0; b < LANES; b++) begin : g_bank
      localparam logic [EXT-1:0] BR = EXT'(b / Q);
      localparam logic [EXT-1:0] BC = EXT'(b % Q);
      logic [EXT-1:0] dr, dc, ln;
      assign dr = (BR + PE - ph_r) % PE;
      assign dc = (BC + QE - ph_c) % QE;
      assign ln = dr * QE + dc;
      assign bank_lane[b] = ln[BIW-1:0];
      assign bank_addr[b] = lane_addr[ln[BIW-1:0]];
   end

endmodule

// File: rtl/prf_xbar.sv
module prf_xbar #(
   parameter int N  = 4,
   parameter int SW = 2,
   parameter int DW = 64
) (
   input  logic [DW-1:0] din  [N],
   input  logic [SW-1:0] sel  [N],
   output logic [DW-1:0] dout [N]
);
   for (genvar k = 0; k < N; k++) begin : g_out
      assign dout[k] = din[sel[k]];
   end
endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int DW    = 64,
   parameter int NRD   = 2
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr [NRD],
   output logic [DW-1:0] rq    [NRD]
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      for (int i = 0; i < NRD; i++) rq[i] <= mem[raddr[i]];
   end
endmodule

// File: rtl/prf_rf.sv
module prf_rf #(
   parameter int P    = 2,
   parameter int Q    = 2,
   parameter int H    = 8,
   parameter int W    = 8,
   parameter int DW   = 64,
   parameter int NREG = 8,
   localparam int LANES = P * Q,
   localparam int RIW   = $clog2(NREG),
   localparam int RW    = $clog2(H),
   localparam int CW    = $clog2(W),
   localparam int LRW   = $clog2(H + 1),
   localparam int LCW   = $clog2(W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [RIW-1:0]      cfg_idx,
   input  logic [RW-1:0]       cfg_row,
   input  logic [CW-1:0]       cfg_col,
   input  logic [LRW-1:0]      cfg_vlen,
   input  logic [LCW-1:0]      cfg_hlen,
   input  logic [1:0]          cfg_ew,
   input  logic                wr_en,
   input  logic [RIW-1:0]      wr_reg,
   input  logic [RW-1:0]       wr_orow,
   input  logic [CW-1:0]       wr_ocol,
   input  logic [LANES*DW-1:0] wr_data,
   output logic                wr_err,
   input  logic [RIW-1:0]      rd0_reg,
   input  logic [RW-1:0]       rd0_orow,
   input  logic [CW-1:0]       rd0_ocol,
   output logic [LANES*DW-1:0] rd0_data,
   output logic                rd0_err,
   output logic [1:0]          rd0_ew,
   input  logic [RIW-1:0]      rd1_reg,
   input  logic [RW-1:0]       rd1_orow,
   input  logic [CW-1:0]       rd1_ocol,
   output logic [LANES*DW-1:0] rd1_data,
   output logic                rd1_err,
   output logic [1:0]          rd1_ew
);
   import prf_pkg::*;

   localparam int BIW   = $clog2(LANES);
   localparam int DEPTH = (H * W) / LANES;
   localparam int AW    = $clog2(DEPTH);
   localparam int NP    = NUM_AG;

   // elaboration-time parameter checks
   if (LANES < 2)                   begin : g_bad_lanes $error("P*Q must be at least 2"); end
   if ((H % P) != 0)                begin : g_bad_h     $error("H must be a multiple of P"); end
   if ((W % Q) != 0)                begin : g_bad_w     $error("W must be a multiple of Q"); end
   if ((H & (H - 1)) != 0)          begin : g_bad_hp2   $error("H must be a power of two"); end
   if ((W & (W - 1)) != 0)          begin : g_bad_wp2   $error("W must be a power of two"); end
   if ((NREG & (NREG - 1)) != 0)    begin : g_bad_nreg  $error("NREG must be a power of two"); end
   if (H < P || W < Q)              begin : g_bad_fit   $error("array smaller than one block"); end

   // per-generator access fields: index 0 = write, 1.. = read ports
   logic [RIW-1:0] g_reg  [NP];
   logic [RW-1:0]  g_orow [NP];
   logic [CW-1:0]  g_ocol [NP];

   assign g_reg[0]  = wr_reg;   assign g_orow[0] = wr_orow;  assign g_ocol[0] = wr_ocol;
   assign g_reg[1]  = rd0_reg;  assign g_orow[1] = rd0_orow; assign g_ocol[1] = rd0_ocol;
   assign g_reg[2]  = rd1_reg;  assign g_orow[2] = rd1_orow; assign g_ocol[2] = rd1_ocol;

   logic [RW-1:0]  d_row  [NP];
   logic [CW-1:0]  d_col  [NP];
   logic [LRW-1:0] d_vlen [NP];
   logic [LCW-1:0] d_hlen [NP];
   logic [1:0]     d_ew   [NP];

   prf_desc_table #(
      .NREG(NREG), .NPORT(NP), .H(H), .W(W),
      .RIW(RIW), .RW(RW), .CW(CW), .LRW(LRW), .LCW(LCW)
   ) desc_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_row(cfg_row), .cfg_col(cfg_col),
      .cfg_vlen(cfg_vlen), .cfg_hlen(cfg_hlen), .cfg_ew(cfg_ew),
      .look_idx(g_reg), .look_row(d_row), .look_col(d_col),
      .look_vlen(d_vlen), .look_hlen(d_hlen), .look_ew(d_ew)
   );

   logic [BIW-1:0] lane_bank [NP][LANES];
   logic [BIW-1:0] bank_lane [NP][LANES];
   logic [AW-1:0]  bank_addr [NP][LANES];
   logic           acc_err   [NP];

   for (genvar g = 0; g < NP; g++) begin : g_agu
      prf_agu #(
         .P(P), .Q(Q), .H(H), .W(W), .RW(RW), .CW(CW),
         .LRW(LRW), .LCW(LCW), .AW(AW), .BIW(BIW)
      ) agu_i (
         .base_r(d_row[g]), .base_c(d_col[g]),
         .vlen(d_vlen[g]), .hlen(d_hlen[g]),
         .off_r(g_orow[g]), .off_c(g_ocol[g]),
         .lane_bank(lane_bank[g]), .bank_lane(bank_lane[g]),
         .bank_addr(bank_addr[g]), .err(acc_err[g])
      );
   end

   // write shuffle: lanes -> banks
   logic [DW-1:0]    w_lane [LANES];
   logic [DW-1:0]    w_bank [LANES];
   logic [LANES-1:0] bank_we;
   logic             wr_ok;

   for (genvar l = 0; l < LANES; l++) begin : g_wunpack
      assign w_lane[l] = wr_data[l*DW +: DW];
   end

   prf_xbar #(.N(LANES), .SW(BIW), .DW(DW)) wxbar_i (
      .din(w_lane), .sel(bank_lane[0]), .dout(w_bank)
   );

   assign wr_ok = wr_en && !acc_err[0];

   // banks
   logic [AW-1:0] b_raddr [LANES][NUM_RD];
   logic [DW-1:0] b_rq    [LANES][NUM_RD];
   logic [DW-1:0] p_rq    [NUM_RD][LANES];

   for (genvar b = 0; b < LANES; b++) begin : g_bank
      assign bank_we[b] = wr_ok;
      for (genvar r = 0; r < NUM_RD; r++) begin : g_rp
         assign b_raddr[b][r] = bank_addr[r+1][b];
         assign p_rq[r][b]    = b_rq[b][r];
      end
      prf_bank #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NRD(NUM_RD)) bank_i (
         .clk(clk), .we(bank_we[b]), .waddr(bank_addr[0][b]), .wdata(w_bank[b]),
         .raddr(b_raddr[b]), .rq(b_rq[b])
      );
   end

   // read pipeline stage: lane select, flags, width code
   logic [BIW-1:0]      sel_q [NUM_RD][LANES];
   logic                err_q [NUM_RD];
   logic [1:0]          ew_q  [NUM_RD];
   logic                live_q;
   logic                wr_err_q;
   logic [DW-1:0]       r_lane [NUM_RD][LANES];
   logic [LANES*DW-1:0] r_flat [NUM_RD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q   <= 1'b0;
         wr_err_q <= 1'b0;
         for (int r = 0; r < NUM_RD; r++) begin
            err_q[r] <= 1'b0;
            ew_q[r]  <= '0;
            for (int l = 0; l < LANES; l++) sel_q[r][l] <= '0;
         end
      end else begin
         live_q   <= 1'b1;
         wr_err_q <= wr_en && acc_err[0];
         for (int r = 0; r < NUM_RD; r++) begin
            err_q[r] <= acc_err[r+1];
            ew_q[r]  <= d_ew[r+1];
            for (int l = 0; l < LANES; l++) sel_q[r][l] <= lane_bank[r+1][l];
         end
      end
   end

   // read shuffle: banks -> lanes
   for (genvar r = 0; r < NUM_RD; r++) begin : g_rxbar
      prf_xbar #(.N(LANES), .SW(BIW), .DW(DW)) rxbar_i (
         .din(p_rq[r]), .sel(sel_q[r]), .dout(r_lane[r])
      );
      for (genvar l = 0; l < LANES; l++) begin : g_pack
         assign r_flat[r][l*DW +: DW] = (live_q && !err_q[r]) ? r_lane[r][l] : '0;
      end
   end

   assign rd0_data = r_flat[0];
   assign rd1_data = r_flat[1];
   assign rd0_err  = err_q[0];
   assign rd1_err  = err_q[1];
   assign rd0_ew   = ew_q[0];
   assign rd1_ew   = ew_q[1];
   assign wr_err   = wr_err_q;

endmodule

// File: rtl/prf_rf_chk.sv
module prf_rf_chk #(
   parameter int LANES = 4,
   parameter int BIW   = 2,
   parameter int DW    = 64,
   parameter int NP    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                wr_err,
   input logic                rd0_err,
   input logic                rd1_err,
   input logic [LANES*DW-1:0] rd0_data,
   input logic [LANES*DW-1:0] rd1_data,
   input logic [LANES-1:0]    bank_we,
   input logic [BIW-1:0]      lane_bank [NP][LANES]
);
   logic [LANES-1:0] cover_v [NP];

   always_comb begin
      for (int g = 0; g < NP; g++) begin
         cover_v[g] = '0;
         for (int l = 0; l < LANES; l++) cover_v[g][lane_bank[g][l]] = 1'b1;
      end
   end

   // R4: the lanes of each generator hit every bank exactly once
   a_r4_wr_banks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      cover_v[0] == '1);
   a_r4_rd0_banks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      cover_v[1] == '1);
   a_r4_rd1_banks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      cover_v[2] == '1);

   // R10: error flag only follows a write request
   a_r10_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));

   // R10: a flagged write left every bank untouched
   a_r10_no_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> ($past(bank_we) == '0));

   // R8: a read in error carries zero data
   a_r8_rd0_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_err |-> (rd0_data == '0));

   // R9: same on the second port
   a_r9_rd1_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd1_err |-> (rd1_data == '0));

endmodule

bind prf_rf prf_rf_chk #(.LANES(LANES), .BIW(BIW), .DW(DW), .NP(NP)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_err(wr_err),
   .rd0_err(rd0_err), .rd1_err(rd1_err), .rd0_data(rd0_data), .rd1_data(rd1_data),
   .bank_we(bank_we), .lane_bank(lane_bank)
);

// File: tb/prf_rf_tb.sv
`timescale 1ns/1ps
module prf_rf_tb_top;
   localparam int P = 2, Q = 2, H = 8, W = 8, DW = 64, NREG = 8;
   localparam int LANES = P * Q;
   localparam int BW = LANES * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0, cfg_row = '0, cfg_col = '0;
   logic [3:0]    cfg_vlen = '0, cfg_hlen = '0;
   logic [1:0]    cfg_ew = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_reg = '0, wr_orow = '0, wr_ocol = '0;
   logic [BW-1:0] wr_data = '0;
   logic          wr_err;
   logic [2:0]    rd0_reg = '0, rd0_orow = '0, rd0_ocol = '0;
   logic [2:0]    rd1_reg = '0, rd1_orow = '0, rd1_ocol = '0;
   logic [BW-1:0] rd0_data, rd1_data;
   logic          rd0_err, rd1_err;
   logic [1:0]    rd0_ew, rd1_ew;

   always #2.5 clk = ~clk;

   prf_rf #(.P(P), .Q(Q), .H(H), .W(W), .DW(DW), .NREG(NREG)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_row(cfg_row), .cfg_col(cfg_col),
      .cfg_vlen(cfg_vlen), .cfg_hlen(cfg_hlen), .cfg_ew(cfg_ew),
      .wr_en(wr_en), .wr_reg(wr_reg), .wr_orow(wr_orow), .wr_ocol(wr_ocol),
      .wr_data(wr_data), .wr_err(wr_err),
      .rd0_reg(rd0_reg), .rd0_orow(rd0_orow), .rd0_ocol(rd0_ocol),
      .rd0_data(rd0_data), .rd0_err(rd0_err), .rd0_ew(rd0_ew),
      .rd1_reg(rd1_reg), .rd1_orow(rd1_orow), .rd1_ocol(rd1_ocol),
      .rd1_data(rd1_data), .rd1_err(rd1_err), .rd1_ew(rd1_ew)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench models
   logic [DW-1:0] mem [H][W];
   int m_r [NREG], m_c [NREG], m_vl [NREG], m_hl [NREG], m_ew [NREG];

   task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                        input logic [BW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] lane_val(int pass, int r, int c, int l);
      return {16'(pass), 16'(r), 16'(c), 16'(l)};
   endfunction

   function automatic bit blk_err(int g, int orow, int ocol);
      return (orow + P > m_vl[g]) || (ocol + Q > m_hl[g]) ||
             (m_r[g] + orow + P > H) || (m_c[g] + ocol + Q > W);
   endfunction

   function automatic logic [BW-1:0] blk_data(int g, int orow, int ocol);
      logic [BW-1:0] d = '0;
      if (!blk_err(g, orow, ocol))
         for (int l = 0; l < LANES; l++)
            d[l*DW +: DW] = mem[m_r[g] + orow + l / Q][m_c[g] + ocol + l % Q];
      return d;
   endfunction

   task automatic cfg(input int g, input int r, input int c, input int vl,
                      input int hl, input int ew);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(g); cfg_row = 3'(r); cfg_col = 3'(c);
      cfg_vlen = 4'(vl); cfg_hlen = 4'(hl); cfg_ew = 2'(ew);
      @(negedge clk);
      cfg_we = 1'b0;
      m_r[g] = r; m_c[g] = c; m_vl[g] = vl; m_hl[g] = hl; m_ew[g] = ew;
   endtask

   // both read ports in one cycle; results checked one edge later
   task automatic rd2(input int g0, input int r0, input int c0,
                      input int g1, input int r1, input int c1, input string req);
      logic [BW-1:0] e0, e1;
      bit x0, x1;
      e0 = blk_data(g0, r0, c0); x0 = blk_err(g0, r0, c0);
      e1 = blk_data(g1, r1, c1); x1 = blk_err(g1, r1, c1);
      @(negedge clk);
      rd0_reg = 3'(g0); rd0_orow = 3'(r0); rd0_ocol = 3'(c0);
      rd1_reg = 3'(g1); rd1_orow = 3'(r1); rd1_ocol = 3'(c1);
      @(negedge clk);
      check(rd0_data === e0, {req, " rd0 data"}, rd0_data, e0);
      check(rd1_data === e1, {req, " rd1 data"}, rd1_data, e1);
      check(rd0_err === x0 && rd1_err === x1, {req, " err flags"},
            BW'({rd0_err, rd1_err}), BW'({x0, x1}));
      check(rd0_ew === 2'(m_ew[g0]) && rd1_ew === 2'(m_ew[g1]), "R7 width code",
            BW'({rd0_ew, rd1_ew}), BW'({2'(m_ew[g0]), 2'(m_ew[g1])}));
   endtask

   task automatic wr(input int g, input int orow, input int ocol, input int pass,
                     input string req);
      bit x;
      x = blk_err(g, orow, ocol);
      @(negedge clk);
      wr_en = 1'b1; wr_reg = 3'(g); wr_orow = 3'(orow); wr_ocol = 3'(ocol);
      for (int l = 0; l < LANES; l++)
         wr_data[l*DW +: DW] = lane_val(pass, m_r[g] + orow, m_c[g] + ocol, l);
      @(negedge clk);
      wr_en = 1'b0;
      check(wr_err === x, {req, " wr_err"}, BW'(wr_err), BW'(x));
      if (!x)
         for (int l = 0; l < LANES; l++)
            mem[m_r[g] + orow + l / Q][m_c[g] + ocol + l % Q] =
               lane_val(pass, m_r[g] + orow, m_c[g] + ocol, l);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int g = 0; g < NREG; g++) begin
         m_r[g] = 0; m_c[g] = 0; m_vl[g] = H; m_hl[g] = W; m_ew[g] = 3;
      end
      // R1: state during reset
      repeat (3) @(negedge clk);
      check(rd0_err === 1'b0 && rd1_err === 1'b0 && wr_err === 1'b0, "R1 flags in reset",
            BW'({rd0_err, rd1_err, wr_err}), '0);
      check(rd0_data === '0 && rd1_data === '0, "R1 data in reset", rd0_data, '0);
      rst_n = 1'b1;

      // R2 R3: fill with aligned blocks through the full-array default register
      for (int r = 0; r < H; r += P)
         for (int c = 0; c < W; c += Q)
            wr(0, r, c, 1, "R3 aligned fill");
      // R1 default descriptor, R4 R5: every alignment on both ports at once
      for (int r = 0; r <= H - P; r++)
         for (int c = 0; c <= W - Q; c++)
            rd2(0, r, c, 0, H - P - r, W - Q - c, "R2 R4 R5 sweep");

      // R3: overlapping writes at every alignment, each read back next cycle
      for (int r = 0; r <= H - P; r++)
         for (int c = 0; c <= W - Q; c++) begin
            wr(0, r, c, 2 + r * 8 + c, "R3 unaligned write");
            rd2(0, r, c, 0, 0, 0, "R3 read after write");
         end
      for (int r = 0; r <= H - P; r++)
         for (int c = 0; c <= W - Q; c++)
            rd2(0, r, c, 0, c, r, "R2 R4 final contents");

      // R7: small register, other width code
      cfg(3, 3, 2, 3, 4, 1);
      rd2(3, 0, 0, 3, 1, 2, "R7 resized register");
      // R8: past register extent
      rd2(3, 2, 0, 3, 0, 3, "R8 past extent");
      rd2(3, 1, 0, 0, 0, 0, "R8 last legal row");
      // R9: register reaching past the array edge
      cfg(4, 6, 6, 4, 4, 2);
      rd2(4, 0, 0, 4, 1, 0, "R9 array edge row");
      rd2(4, 0, 1, 4, 0, 0, "R9 array edge col");
      // R10: dropped write leaves the target untouched
      wr(3, 2, 0, 900, "R10 dropped write");
      rd2(0, 5, 2, 0, 4, 2, "R10 target unchanged");
      wr(4, 1, 1, 901, "R10 dropped edge write");
      rd2(0, 6, 6, 0, 6, 5, "R10 edge unchanged");
      // R7: move register 3, same access fields now reach the new place
      cfg(3, 0, 4, 2, 2, 0);
      rd2(3, 0, 0, 3, 0, 0, "R7 moved register");

      // R6: read and write to one block in the same cycle return old data
      begin
         logic [BW-1:0] old_v;
         old_v = blk_data(0, 2, 3);
         @(negedge clk);
         wr_en = 1'b1; wr_reg = 3'd0; wr_orow = 3'd2; wr_ocol = 3'd3;
         for (int l = 0; l < LANES; l++) wr_data[l*DW +: DW] = lane_val(777, 2, 3, l);
         rd0_reg = 3'd0; rd0_orow = 3'd2; rd0_ocol = 3'd3;
         @(negedge clk);
         wr_en = 1'b0;
         check(rd0_data === old_v, "R6 old value on collision", rd0_data, old_v);
         for (int l = 0; l < LANES; l++) mem[2 + l / Q][3 + l % Q] = lane_val(777, 2, 3, l);
         rd2(0, 2, 3, 0, 1, 2, "R6 new value next cycle");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule